// File: doc/BRIEF.md
# Two-Bank SDRAM Command Legality Monitor

This block sits beside a synchronous DRAM command bus and watches it without driving anything. On every clock it decodes the chip-select, row-strobe, column-strobe, write-enable, clock-enable, auto-precharge address bit and bank-select lines into a command. It checks that command against the state it keeps for each bank. The block knows the burst length and the precharge, active-to-precharge and write-recovery times as clock counts. From these it follows each bank through its open row, its bursts, the auto-precharge chain and the precharge itself.

When a command is not allowed in a bank's current state, the monitor raises a one-cycle error flag. The flag comes with a code for the rejected command and the index of the bank that refused it. The rejected command then counts only as a no-operation, so the tracked state stays in step with a device that would ignore it. The per-bank state is always visible on an output bus, for a scoreboard or a debug probe.

Top module: `sdr_cmd_monitor`

## Requirements
- R1: After reset, every bank reports state 0 (idle) and `err_valid` is low.
- R2: Commands decode from {cs_n, ras_n, cas_n, we_n} with these codes: cs_n high = DESL (0, whatever the other pins are); 0111 = NOP (1); 0110 = BST (2); 0101 = READ (3), or READA (4) with ap_a10 high; 0100 = WRIT (5), or WRITA (6) with ap_a10 high; 0011 = ACT (7); 0010 = PRE (8), or PALL (9) with ap_a10 high; 0001 = REF (10); 0000 = MRS (11). While cke is low, the command is taken as NOP and is never flagged.
- R3: In idle, READ, READA, WRIT and WRITA are illegal. ACT moves the bank to active (1). PRE, PALL, DESL, NOP and BST are accepted and change nothing.
- R4: ACT to the selected bank is illegal in every state except idle, including precharging (7). A bank therefore cannot reopen until its T_RP precharge cycles have run out.
- R5: PRE or PALL to a bank that is active, reading or writing is illegal until T_RAS cycles have passed since that bank's accepted ACT.
- R6: READ or WRIT in an active, reading (2) or writing (3) bank starts a fresh burst of BURST_LEN cycles in state 2 or 3, which then returns to active. An accepted BST returns every reading or writing bank to active at once.
- R7: READA enters state 4 for BURST_LEN cycles, then precharging. WRITA enters state 5 for BURST_LEN cycles, then write recovery (6) for T_WR cycles, then precharging. Precharging lasts T_RP cycles and ends in idle.
- R8: In states 4 and 5, BST, every read or write to that bank, ACT to that bank, and PRE or PALL are illegal.
- R9: In write recovery (6), BST is accepted as a no-operation. Read, write, ACT or PRE to that bank, and PALL, are illegal.
- R10: PALL is checked against every bank. When accepted, it moves every bank in state 1, 2 or 3 into precharging.
- R11: REF and MRS are legal only when every bank is idle, and they change no bank state.
- R12: A rejected command raises `err_valid` for the one cycle after the clock edge that sampled it, with `err_cmd` set to its code. `err_bank` is set to the selected bank, or, for BST, PALL, REF and MRS, to the lowest-numbered bank that refused. The rejected command has the effect of a NOP, and all bank timers keep running.
- R13: `bank_state[3*b+2:3*b]` carries bank b's state: 0 idle, 1 active, 2 reading, 3 writing, 4 reading with auto-precharge, 5 writing with auto-precharge, 6 write recovery, 7 precharging.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all lines are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable; low means no command is taken |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ap_a10 | input | 1 | Auto-precharge / all-banks address bit |
| ba | input | BA_W | Bank select |
| err_valid | output | 1 | One-cycle flag for a rejected command |
| err_cmd | output | 4 | Code of the rejected command |
| err_bank | output | BA_W | Bank that refused the command |
| bank_state | output | 3*BANKS | Current state of each bank |

## Verification
The hardest cases to reach from the pins come from timers. A command may land in the last cycle of a burst, a write recovery or a precharge. A PRE may come exactly one cycle before or exactly at the T_RAS limit. The error code and bank depend on those exact cycles. Directed sequences count NOPs to put READ, BST, ACT and PRE on either side of each of these limits, and walk the full write-with-auto-precharge chain. A long random stream, weighted toward NOPs so that timers expire between commands, is then checked cycle by cycle against a behavioural model of both banks.

// File: rtl/sdrmon_pkg.sv
package sdrmon_pkg;

    typedef enum logic [3:0] {
        C_DESL  = 4'd0,
        C_NOP   = 4'd1,
        C_BST   = 4'd2,
        C_READ  = 4'd3,
        C_READA = 4'd4,
        C_WRIT  = 4'd5,
        C_WRITA = 4'd6,
        C_ACT   = 4'd7,
        C_PRE   = 4'd8,
        C_PALL  = 4'd9,
        C_REF   = 4'd10,
        C_MRS   = 4'd11
    } cmd_e;

    typedef enum logic [2:0] {
        B_IDLE     = 3'd0,
        B_ACTIVE   = 3'd1,
        B_READ     = 3'd2,
        B_WRITE    = 3'd3,
        B_READ_AP  = 3'd4,
        B_WRITE_AP = 3'd5,
        B_WR_RECOV = 3'd6,
        B_PRECHG   = 3'd7
    } bank_e;

endpackage

// File: rtl/sdrmon_decode.sv
module sdrmon_decode
    import sdrmon_pkg::*;
(
    input  logic cke,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic ap_a10,
    output cmd_e cmd
);

    always_comb begin
        if (!cke) begin
            cmd = C_NOP;
        end else if (cs_n) begin
            cmd = C_DESL;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b111:  cmd = C_NOP;
                3'b110:  cmd = C_BST;
                3'b101:  cmd = ap_a10 ? C_READA : C_READ;
                3'b100:  cmd = ap_a10 ? C_WRITA : C_WRIT;
                3'b011:  cmd = C_ACT;
                3'b010:  cmd = ap_a10 ? C_PALL : C_PRE;
                3'b001:  cmd = C_REF;
                default: cmd = C_MRS;
            endcase
        end
    end

endmodule

// File: rtl/sdrmon_bank.sv
module sdrmon_bank
    import sdrmon_pkg::*;
#(
    parameter int BURST_LEN = 4,
    parameter int T_RP      = 3,
    parameter int T_RAS     = 5,
    parameter int T_WR      = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  cmd_e  cmd,
    input  logic  hit,
    input  logic  accept,
    output logic  reject,
    output bank_e state
);

    localparam int M_A  = (BURST_LEN > T_RP) ? BURST_LEN : T_RP;
    localparam int M_B  = (T_WR > T_RAS) ? T_WR : T_RAS;
    localparam int MAXV = (M_A > M_B) ? M_A : M_B;
    localparam int CW   = $clog2(MAXV + 1);

    localparam logic [CW-1:0] BL_C  = CW'(BURST_LEN);
    localparam logic [CW-1:0] RP_C  = CW'(T_RP);
    localparam logic [CW-1:0] WR_C  = CW'(T_WR);
    localparam logic [CW-1:0] RAS_C = CW'(T_RAS - 1);
    localparam logic [CW-1:0] ONE_C = CW'(1);

    typedef struct packed {
        bank_e         st;
        logic [CW-1:0] cnt;
        logic [CW-1:0] ras;
    } regs_t;

    regs_t q, d;
    logic  open_row;
    logic  ap_burst;
    logic  pre_req;
    logic  moved;
    logic  last;

    // legality of the sampled command against this bank
    always_comb begin
        open_row = (q.st == B_ACTIVE) || (q.st == B_READ) || (q.st == B_WRITE);
        ap_burst = (q.st == B_READ_AP) || (q.st == B_WRITE_AP);
        pre_req  = (cmd == C_PALL) || ((cmd == C_PRE) && hit);
        reject   = 1'b0;
        unique case (cmd)
            C_BST:
                reject = ap_burst;
            C_READ, C_READA, C_WRIT, C_WRITA:
                reject = hit && !open_row;
            C_ACT:
                reject = hit && (q.st != B_IDLE);
            C_PRE, C_PALL:
                reject = pre_req && (ap_burst || (q.st == B_WR_RECOV) ||
                                     (open_row && (q.ras != '0)));
            C_REF, C_MRS:
                reject = (q.st != B_IDLE);
            default:
                reject = 1'b0;
        endcase
    end

    // next-state computation
    always_comb begin
        d     = q;
        moved = 1'b0;
        last  = (q.cnt == ONE_C);
        d.ras = (q.ras != '0) ? (q.ras - ONE_C) : '0;

        if (accept) begin
            unique case (cmd)
                C_BST: begin
                    if ((q.st == B_READ) || (q.st == B_WRITE)) begin
                        d.st  = B_ACTIVE;
                        moved = 1'b1;
                    end
                end
                C_READ, C_READA, C_WRIT, C_WRITA: begin
                    if (hit) begin
                        unique case (cmd)
                            C_READ:  d.st = B_READ;
                            C_READA: d.st = B_READ_AP;
                            C_WRIT:  d.st = B_WRITE;
                            default: d.st = B_WRITE_AP;
                        endcase
                        d.cnt = BL_C;
                        moved = 1'b1;
                    end
                end
                C_ACT: begin
                    if (hit) begin
                        d.st  = B_ACTIVE;
                        d.ras = RAS_C;
                        moved = 1'b1;
                    end
                end
                C_PRE, C_PALL: begin
                    if (pre_req && open_row) begin
                        d.st  = B_PRECHG;
                        d.cnt = RP_C;
                        moved = 1'b1;
                    end
                end
                default: moved = 1'b0;
            endcase
        end

        if (!moved) begin
            unique case (q.st)
                B_READ, B_WRITE: begin
                    if (last) d.st = B_ACTIVE;
                    else      d.cnt = q.cnt - ONE_C;
                end
                B_READ_AP: begin
                    if (last) begin
                        d.st  = B_PRECHG;
                        d.cnt = RP_C;
                    end else begin
                        d.cnt = q.cnt - ONE_C;
                    end
                end
                B_WRITE_AP: begin
                    if (last) begin
                        d.st  = B_WR_RECOV;
                        d.cnt = WR_C;
                    end else begin
                        d.cnt = q.cnt - ONE_C;
                    end
                end
                B_WR_RECOV: begin
                    if (last) begin
                        d.st  = B_PRECHG;
                        d.cnt = RP_C;
                    end else begin
                        d.cnt = q.cnt - ONE_C;
                    end
                end
                B_PRECHG: begin
                    if (last) d.st = B_IDLE;
                    else      d.cnt = q.cnt - ONE_C;
                end
                default: d.cnt = q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st  <= B_IDLE;
            q.cnt <= '0;
            q.ras <= '0;
        end else begin
            q <= d;
        end
    end

    assign state = q.st;

endmodule

// File: rtl/sdr_cmd_monitor.sv
module sdr_cmd_monitor
    import sdrmon_pkg::*;
#(
    parameter int BANKS     = 2,
    parameter int BURST_LEN = 4,
    parameter int T_RP      = 3,
    parameter int T_RAS     = 5,
    parameter int T_WR      = 2,
    localparam int BA_W     = (BANKS > 1) ? $clog2(BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cke,
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic                 ap_a10,
    input  logic [BA_W-1:0]      ba,
    output logic                 err_valid,
    output logic [3:0]           err_cmd,
    output logic [BA_W-1:0]      err_bank,
    output logic [3*BANKS-1:0]   bank_state
);

    typedef struct packed {
        logic            v;
        logic [3:0]      code;
        logic [BA_W-1:0] bank;
    } err_t;

    cmd_e             cmd;
    logic [BANKS-1:0] rej;
    logic             accept;
    err_t             err_d, err_q;

    sdrmon_decode u_dec (
        .cke    (cke),
        .cs_n   (cs_n),
        .ras_n  (ras_n),
        .cas_n  (cas_n),
        .we_n   (we_n),
        .ap_a10 (ap_a10),
        .cmd    (cmd)
    );

    assign accept = ~|rej;

    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        bank_e st;
        logic  hit;

        assign hit = (ba == BA_W'(g));

        sdrmon_bank #(
            .BURST_LEN (BURST_LEN),
            .T_RP      (T_RP),
            .T_RAS     (T_RAS),
            .T_WR      (T_WR)
        ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .cmd    (cmd),
            .hit    (hit),
            .accept (accept),
            .reject (rej[g]),
            .state  (st)
        );

        assign bank_state[3*g +: 3] = st;
    end

    always_comb begin
        err_d      = '0;
        err_d.v    = !accept;
        err_d.code = cmd;
        for (int i = BANKS - 1; i >= 0; i--) begin
            if (rej[i]) err_d.bank = BA_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= err_d;
    end

    assign err_valid = err_q.v;
    assign err_cmd   = err_q.code;
    assign err_bank  = err_q.bank;

endmodule

// File: rtl/sdrmon_checker.sv
module sdrmon_checker #(
    parameter int BANKS = 2,
    parameter int BA_W  = 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cke,
    input logic               cs_n,
    input logic               ras_n,
    input logic               cas_n,
    input logic               we_n,
    input logic [BA_W-1:0]    ba,
    input logic               err_valid,
    input logic [3:0]         err_cmd,
    input logic [3*BANKS-1:0] bank_state
);

    // R12
    err_from_real_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> $past(cke && !cs_n && !(ras_n && cas_n && we_n)));

    // R2
    err_code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> (err_cmd >= 4'd2 && err_cmd <= 4'd11));

    for (genvar g = 0; g < BANKS; g++) begin : g_chk
        // R3
        open_needs_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(bank_state[3*g +: 3]) == 3'd0 && bank_state[3*g +: 3] != 3'd0)
            |-> (bank_state[3*g +: 3] == 3'd1 &&
                 $past(cke && !cs_n && !ras_n && cas_n && we_n && ba == BA_W'(g))));

        // R4
        prechg_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(bank_state[3*g +: 3]) == 3'd7)
            |-> (bank_state[3*g +: 3] == 3'd7 || bank_state[3*g +: 3] == 3'd0));

        // R7
        wrap_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(bank_state[3*g +: 3]) == 3'd5)
            |-> (bank_state[3*g +: 3] == 3'd5 || bank_state[3*g +: 3] == 3'd6));

        // R9
        recov_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(bank_state[3*g +: 3]) == 3'd6)
            |-> (bank_state[3*g +: 3] == 3'd6 || bank_state[3*g +: 3] == 3'd7));
    end

endmodule

bind sdr_cmd_monitor sdrmon_checker #(.BANKS(BANKS), .BA_W(BA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cke        (cke),
    .cs_n       (cs_n),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .ba         (ba),
    .err_valid  (err_valid),
    .err_cmd    (err_cmd),
    .bank_state (bank_state)
);

// File: tb/sdr_cmd_monitor_test.sv
module sdr_cmd_monitor_test;

    localparam int BL   = 4;
    localparam int TRP  = 3;
    localparam int TRAS = 5;
    localparam int TWR  = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cke = 1'b1;
    logic       cs_n = 1'b1;
    logic       ras_n = 1'b1;
    logic       cas_n = 1'b1;
    logic       we_n = 1'b1;
    logic       ap_a10 = 1'b0;
    logic [0:0] ba = 1'b0;
    logic       err_valid;
    logic [3:0] err_cmd;
    logic [0:0] err_bank;
    logic [5:0] bank_state;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 0;
    int  ms[2];
    int  mc[2];
    int  mr[2];
    int  e_v;
    int  e_code;
    int  e_bank;

    always #5 clk = ~clk;

    sdr_cmd_monitor #(
        .BANKS(2), .BURST_LEN(BL), .T_RP(TRP), .T_RAS(TRAS), .T_WR(TWR)
    ) uut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ap_a10(ap_a10), .ba(ba),
        .err_valid(err_valid), .err_cmd(err_cmd), .err_bank(err_bank),
        .bank_state(bank_state)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    function automatic int pin_cmd();
        if (!cke) return 1;
        if (cs_n) return 0;
        case ({ras_n, cas_n, we_n})
            3'b111: return 1;
            3'b110: return 2;
            3'b101: return ap_a10 ? 4 : 3;
            3'b100: return ap_a10 ? 6 : 5;
            3'b011: return 7;
            3'b010: return ap_a10 ? 9 : 8;
            3'b001: return 10;
            default: return 11;
        endcase
    endfunction

    // behavioural model of both banks
    task automatic model(int c, int b);
        int rej[2];
        int any;
        for (int k = 0; k < 2; k++) begin
            bit tgt = (k == b);
            bit opn = (ms[k] >= 1 && ms[k] <= 3);
            bit apb = (ms[k] == 4 || ms[k] == 5);
            bit preq = (c == 9) || (c == 8 && tgt);
            rej[k] = 0;
            if (c == 2) rej[k] = apb;
            else if (c >= 3 && c <= 6) rej[k] = tgt && !opn;
            else if (c == 7) rej[k] = tgt && ms[k] != 0;
            else if (c == 8 || c == 9) rej[k] = preq && (apb || ms[k] == 6 || (opn && mr[k] != 0));
            else if (c == 10 || c == 11) rej[k] = (ms[k] != 0);
        end
        any    = rej[0] | rej[1];
        e_v    = any;
        e_code = c;
        e_bank = rej[0] ? 0 : 1;
        for (int k = 0; k < 2; k++) begin
            bit tgt = (k == b);
            bit opn = (ms[k] >= 1 && ms[k] <= 3);
            bit preq = (c == 9) || (c == 8 && tgt);
            bit ch = 0;
            int nr = (mr[k] > 0) ? mr[k] - 1 : 0;
            if (!any) begin
                if (c == 2 && (ms[k] == 2 || ms[k] == 3)) begin ms[k] = 1; ch = 1; end
                else if (c >= 3 && c <= 6 && tgt) begin
                    ms[k] = (c == 3) ? 2 : (c == 4) ? 4 : (c == 5) ? 3 : 5;
                    mc[k] = BL; ch = 1;
                end
                else if (c == 7 && tgt) begin ms[k] = 1; nr = TRAS - 1; ch = 1; end
                else if ((c == 8 || c == 9) && preq && opn) begin ms[k] = 7; mc[k] = TRP; ch = 1; end
            end
            if (!ch && ms[k] >= 2) begin
                if (mc[k] > 1) mc[k]--;
                else begin
                    case (ms[k])
                        2, 3: ms[k] = 1;
                        4:    begin ms[k] = 7; mc[k] = TRP; end
                        5:    begin ms[k] = 6; mc[k] = TWR; end
                        6:    begin ms[k] = 7; mc[k] = TRP; end
                        default: ms[k] = 0;
                    endcase
                end
            end
            mr[k] = nr;
        end
    endtask

    task automatic check(string tag);
        logic [5:0] exp_st;
        bit bad;
        exp_st = {3'(ms[1]), 3'(ms[0])};
        bad = (err_valid !== 1'(e_v)) || (bank_state !== exp_st) ||
              (e_v != 0 && (err_cmd !== 4'(e_code) || err_bank !== 1'(e_bank)));
        n_chk++;
        if (bad) begin
            n_bad++;
            $display("FAIL %s: actual err=%0b code=%0d bank=%0d st=%h expected err=%0d code=%0d bank=%0d st=%h",
                     tag, err_valid, err_cmd, err_bank, bank_state, e_v, e_code, e_bank, exp_st);
        end
    endtask

    // literal expectation; bs < 0 skips the state comparison
    task automatic lit(string tag, bit v, int code, int bs);
        bit bad;
        bad = (err_valid !== v) || (v && err_cmd !== 4'(code)) ||
              (bs >= 0 && bank_state !== 6'(bs));
        n_chk++;
        if (bad) begin
            n_bad++;
            $display("FAIL %s: actual err=%0b code=%0d st=%h expected err=%0b code=%0d st=%0d",
                     tag, err_valid, err_cmd, bank_state, v, code, bs);
        end
    endtask

    task automatic cyc(bit c_cs, bit c_ras, bit c_cas, bit c_we, bit c_a10, int c_ba, bit c_cke, string tag);
        cs_n = c_cs; ras_n = c_ras; cas_n = c_cas; we_n = c_we;
        ap_a10 = c_a10; ba = 1'(c_ba); cke = c_cke;
        model(pin_cmd(), c_ba);
        @(posedge clk);
        @(negedge clk);
        check(tag);
    endtask

    task automatic nop(string t);              cyc(0, 1, 1, 1, 0, 0, 1, t); endtask
    task automatic act(int b, string t);       cyc(0, 0, 1, 1, 0, b, 1, t); endtask
    task automatic rd(int b, bit ap, string t); cyc(0, 1, 0, 1, ap, b, 1, t); endtask
    task automatic wr(int b, bit ap, string t); cyc(0, 1, 0, 0, ap, b, 1, t); endtask
    task automatic pre(int b, string t);       cyc(0, 0, 1, 0, 0, b, 1, t); endtask
    task automatic pall(string t);             cyc(0, 0, 1, 0, 1, 0, 1, t); endtask
    task automatic bst(string t);              cyc(0, 1, 1, 0, 0, 0, 1, t); endtask
    task automatic refr(string t);             cyc(0, 0, 0, 1, 0, 0, 1, t); endtask
    task automatic mrs(string t);              cyc(0, 0, 0, 0, 0, 0, 1, t); endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R12: actual run still going, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 2; k++) begin ms[k] = 0; mc[k] = 0; mr[k] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        lit("R1 reset", 0, 0, 0);

        // R2: clock enable low and deselect hide a read to an idle bank
        cyc(0, 1, 0, 1, 0, 0, 0, "R2 cke low");
        lit("R2 cke low", 0, 0, 0);
        cyc(1, 1, 0, 1, 0, 0, 1, "R2 deselect");
        lit("R2 deselect", 0, 0, 0);

        // R3: idle behaviour
        rd(0, 0, "R3 read idle");
        lit("R3 read idle", 1, 3, 0);
        wr(1, 1, "R3 writa idle");
        pre(0, "R3 pre idle");
        pall("R3 pall idle");
        bst("R3 bst idle");
        act(0, "R3 act");
        lit("R3 act", 0, 0, 1);

        // R4, R5: reopen and early precharge
        act(0, "R4 act open");
        lit("R4 act open", 1, 7, 1);
        nop("R5"); nop("R5");
        pre(0, "R5 early pre");
        lit("R5 early pre", 1, 8, 1);
        pre(0, "R5 pre at limit");
        lit("R5 pre at limit", 0, 0, 7);
        act(0, "R4 act prechg");
        lit("R4 act prechg", 1, 7, 7);
        nop("R4"); nop("R4");
        lit("R4 idle again", 0, 0, 0);

        // R6: bursts on bank 1
        act(1, "R6");
        rd(1, 0, "R6 read");
        bst("R6 bst");
        lit("R6 bst", 0, 0, 6'b001_000);
        wr(1, 0, "R6 write");
        nop("R6"); nop("R6");
        wr(1, 0, "R6 restart");
        for (int i = 0; i < 5; i++) nop("R6 burst end");

        // R7, R8, R9: write with auto-precharge on bank 0
        act(0, "R7");
        wr(0, 1, "R7 writa");
        bst("R8 bst");
        lit("R8 bst", 1, 2, -1);
        rd(0, 0, "R8 read");
        act(0, "R8 act");
        nop("R7");
        bst("R9 bst");
        lit("R9 bst", 0, 0, -1);
        rd(0, 0, "R9 read");
        lit("R9 read", 1, 3, -1);
        for (int i = 0; i < 5; i++) nop("R7 chain");

        // R7: read with auto-precharge on bank 1
        pre(1, "R7");
        for (int i = 0; i < 4; i++) nop("R7");
        act(1, "R7");
        rd(1, 1, "R7 reada");
        pre(1, "R8 pre in ap");
        for (int i = 0; i < 8; i++) nop("R7 reada chain");

        // R10, R11
        act(0, "R10"); act(1, "R10");
        refr("R11 ref open");
        lit("R11 ref open", 1, 10, -1);
        for (int i = 0; i < 4; i++) nop("R10");
        pall("R10 pall");
        lit("R10 pall", 0, 0, 6'b111_111);
        mrs("R11 mrs prechg");
        lit("R11 mrs prechg", 1, 11, -1);
        for (int i = 0; i < 3; i++) nop("R11");
        refr("R11 ref idle");
        lit("R11 ref idle", 0, 0, 0);
        mrs("R11 mrs idle");

        // R12, R13: random stream against the model
        for (int i = 0; i < 4000; i++) begin
            int sel = $urandom_range(0, 31);
            int b   = $urandom_range(0, 1);
            bit a   = 1'($urandom_range(0, 1));
            bit ck  = ($urandom_range(0, 15) != 0);
            if (sel < 16)      cyc(0, 1, 1, 1, a, b, ck, "R12 rand nop");
            else if (sel < 17) cyc(1, 1'($urandom), 1'($urandom), 1'($urandom), a, b, ck, "R2 rand desl");
            else if (sel < 18) cyc(0, 1, 1, 0, a, b, ck, "R6 rand bst");
            else if (sel < 21) cyc(0, 1, 0, 1, a, b, ck, "R13 rand read");
            else if (sel < 24) cyc(0, 1, 0, 0, a, b, ck, "R13 rand write");
            else if (sel < 28) cyc(0, 0, 1, 1, a, b, ck, "R4 rand act");
            else if (sel < 31) cyc(0, 0, 1, 0, a, b, ck, "R5 rand pre");
            else               cyc(0, 0, 0, 1'($urandom), a, b, ck, "R11 rand ref");
        end

        done = 1;
        summary();
        $finish;
    end

endmodule